// File: doc/BRIEF.md
# Bitfield Clear and Insert Unit

This unit takes one 32-bit instruction word together with the current contents of the two registers that word names, and works out a single register write-back. The word carries one of two operations. The clear operation zeroes a contiguous field of the destination register. The insert operation replaces that field with the low bits of a source register, shifted up to the field's low position. A register-file read port outside the unit supplies both operand values. The unit returns a destination index, a data value, a write-enable and two status flags.

The field bounds come from immediates inside the word. The low position is split across two groups of bits. The unit rejects encodings whose architectural result is undefined, and words that are not this instruction at all. In both cases it suppresses the write. All outputs are registered and appear one clock after the word is presented.

Top module: `bfield_unit`

## Requirements
- R1: A word is recognised only when bits [31:20] are 12'hF36, bit 15 is 0 and bit 5 is 0. Any other valid word raises `out_unknown`, keeps `out_we` low and keeps `out_unpred` low.
- R2: For every valid word, `out_dest` carries bits [11:8] of the word.
- R3: The low position is {bits[14:12], bits[7:6]} and the high position is bits [4:0]. When bits [19:16] are 4'hF, the operation is clear and the written value is the destination operand with bits low..high forced to 0.
- R4: When bits [19:16] are not 4'hF, the operation is insert. The written value is (dest AND NOT mask) OR ((src << low) AND mask), where the mask holds ones at bits low..high.
- R5: A recognised word whose high position is below its low position raises `out_unpred` and keeps `out_we` low.
- R6: A recognised word with destination index 15 raises `out_unpred` and keeps `out_we` low.
- R7: A field with low position 0 and high position 31 covers all 32 bits. Clear then writes 0, and insert writes the source value unchanged.
- R8: `out_valid` rises exactly one cycle after `in_valid` is sampled high. A cycle without `in_valid` leaves `out_valid`, `out_we` and both flags low in the next cycle.
- R9: While `rst` is high, `out_valid`, `out_we`, `out_unpred` and `out_unknown` are 0 in the cycle after each reset edge.
- R10: Whenever `out_valid` is high and `out_we` is low, `out_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| in_insn | input | 32 | Instruction word |
| in_dest_val | input | 32 | Current value of the destination register |
| in_src_val | input | 32 | Current value of the source register |
| out_valid | output | 1 | Result of the previous cycle's word is present |
| out_dest | output | 4 | Destination register index |
| out_data | output | 32 | Write-back value |
| out_we | output | 1 | Write the value to the register file |
| out_unpred | output | 1 | Encoding has an undefined result; write suppressed |
| out_unknown | output | 1 | Word is not a bitfield clear or insert |

## Verification
The bench sweeps every pair of low and high positions for both operations. This covers the full 32-bit field, which a shift-based mask that overflows at width 32 would turn into an empty mask. It also covers every inverted range, which a design that forgets the order check would write back with a garbage mask. Each of the fixed opcode bits is flipped in turn to catch a decoder that ignores one of them. A destination of 15 is driven to catch a write-back to the program counter. Idle cycles and reset cycles are mixed into the stream to catch a valid or write strobe that lingers past its cycle.

// File: rtl/bfield_pkg.sv
package bfield_pkg;

  // Instruction and field geometry fixed by the encoding
  localparam int INSN_W = 32;
  localparam int IDX_W  = 4;
  localparam int POS_W  = 5;
  localparam int DATA_W = 1 << POS_W;

  localparam logic [11:0]      OPC_TOP  = 12'hF36;
  localparam logic [IDX_W-1:0] IDX_PC   = 4'hF;

  typedef struct packed {
    logic             matched;
    logic             is_clear;
    logic [IDX_W-1:0] dest;
    logic [IDX_W-1:0] src;
    logic [POS_W-1:0] lo;
    logic [POS_W-1:0] hi;
    logic             bad_range;
    logic             bad_reg;
  } fld_dec_t;

endpackage

// File: rtl/bfield_decode.sv
module bfield_decode
  import bfield_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output fld_dec_t          dec
);

  logic [IDX_W-1:0] src_f;
  logic [IDX_W-1:0] dst_f;
  logic [POS_W-1:0] lo_f;
  logic [POS_W-1:0] hi_f;
  logic             opc_ok;
  logic             clr;

  always_comb begin
    opc_ok = (insn[31:20] == OPC_TOP) && !insn[15] && !insn[5];
    src_f  = insn[19:16];
    dst_f  = insn[11:8];
    lo_f   = {insn[14:12], insn[7:6]};
    hi_f   = insn[4:0];
    clr    = (src_f == IDX_PC);
  end

  always_comb begin
    dec.matched   = opc_ok;
    dec.is_clear  = clr;
    dec.dest      = dst_f;
    dec.src       = src_f;
    dec.lo        = lo_f;
    dec.hi        = hi_f;
    dec.bad_range = (hi_f < lo_f);
    // the source index only counts for insert; for clear it is the selector
    dec.bad_reg   = (dst_f == IDX_PC) || (!clr && (src_f == IDX_PC));
  end

endmodule

// File: rtl/bfield_mask.sv
module bfield_mask #(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W)
) (
  input  logic [POS_W-1:0]  lo,
  input  logic [POS_W-1:0]  hi,
  output logic [DATA_W-1:0] mask
);

  // Per-bit range compare: no shift of a width count, so a 32-bit field cannot overflow
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign mask[i] = (POS_W'(i) >= lo) && (POS_W'(i) <= hi);
  end

  always_comb begin
    if (hi >= lo) begin
      // R4
      mask_width_chk: assert ($countones(mask) == (int'(hi) - int'(lo) + 1));
    end
    if ((lo == '0) && (hi == '1)) begin
      // R7
      full_mask_chk: assert (mask == '1);
    end
  end

endmodule

// File: rtl/bfield_merge.sv
module bfield_merge #(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W)
) (
  input  logic              is_clear,
  input  logic [POS_W-1:0]  lo,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] dest_val,
  input  logic [DATA_W-1:0] src_val,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] kept;
  logic [DATA_W-1:0] placed;

  always_comb begin
    kept   = dest_val & ~mask;
    placed = (src_val << lo) & mask;
    result = is_clear ? kept : (kept | placed);
  end

endmodule

// File: rtl/bfield_unit.sv
module bfield_unit
  import bfield_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] in_insn,
  input  logic [DATA_W-1:0] in_dest_val,
  input  logic [DATA_W-1:0] in_src_val,
  output logic              out_valid,
  output logic [IDX_W-1:0]  out_dest,
  output logic [DATA_W-1:0] out_data,
  output logic              out_we,
  output logic              out_unpred,
  output logic              out_unknown
);

  fld_dec_t          dec;
  logic [DATA_W-1:0] fmask;
  logic [DATA_W-1:0] merged;
  logic              unpred_c;
  logic              write_c;

  bfield_decode u_dec (
    .insn (in_insn),
    .dec  (dec)
  );

  bfield_mask #(.DATA_W(DATA_W), .POS_W(POS_W)) u_mask (
    .lo   (dec.lo),
    .hi   (dec.hi),
    .mask (fmask)
  );

  bfield_merge #(.DATA_W(DATA_W), .POS_W(POS_W)) u_merge (
    .is_clear (dec.is_clear),
    .lo       (dec.lo),
    .mask     (fmask),
    .dest_val (in_dest_val),
    .src_val  (in_src_val),
    .result   (merged)
  );

  always_comb begin
    unpred_c = dec.matched && (dec.bad_range || dec.bad_reg);
    write_c  = dec.matched && !unpred_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_we      <= 1'b0;
      out_unpred  <= 1'b0;
      out_unknown <= 1'b0;
      out_dest    <= '0;
      out_data    <= '0;
    end else begin
      out_valid   <= in_valid;
      out_we      <= in_valid && write_c;
      out_unpred  <= in_valid && unpred_c;
      out_unknown <= in_valid && !dec.matched;
      if (in_valid) begin
        out_dest <= dec.dest;
        out_data <= write_c ? merged : '0;
      end
    end
  end

  // R1
  unknown_no_we_chk: assert property (@(posedge clk) disable iff (rst)
    out_unknown |-> (!out_we && !out_unpred));

  // R5
  unpred_no_we_chk: assert property (@(posedge clk) disable iff (rst)
    out_unpred |-> !out_we);

  // R6
  pc_dest_no_we_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_dest == IDX_PC) |-> !out_we);

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_we && !out_unpred && !out_unknown));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_we && !out_unpred && !out_unknown));

  // R10
  no_write_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_we) |-> (out_data == '0));

endmodule

// File: tb/bfield_unit_tb.sv
module bfield_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_insn;
  logic [31:0] in_dest_val;
  logic [31:0] in_src_val;
  logic        out_valid;
  logic [3:0]  out_dest;
  logic [31:0] out_data;
  logic        out_we;
  logic        out_unpred;
  logic        out_unknown;

  int errors = 0;
  int checks = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  bfield_unit u_dut (
    .clk, .rst, .in_valid, .in_insn, .in_dest_val, .in_src_val,
    .out_valid, .out_dest, .out_data, .out_we, .out_unpred, .out_unknown
  );

  function automatic logic [31:0] enc(input logic [3:0] s, input logic [3:0] d,
                                     input logic [4:0] lo, input logic [4:0] hi);
    return {12'hF36, s, 1'b0, lo[4:2], d, lo[1:0], 1'b0, hi};
  endfunction

  function automatic logic [31:0] fmask(input int lo, input int hi);
    logic [63:0] w;
    w = ((64'd1 << (hi - lo + 1)) - 64'd1) << lo;
    return w[31:0];
  endfunction

  task automatic next_rand(output logic [31:0] v);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    v = seed;
  endtask

  // drive on negedge, check at the following negedge (one register stage)
  task automatic run(input string req, input logic [31:0] insn,
                     input logic [31:0] dv, input logic [31:0] sv,
                     input logic ev, input logic ewe, input logic eunp,
                     input logic eunk, input logic [3:0] edst, input logic [31:0] edat);
    in_valid = ev; in_insn = insn; in_dest_val = dv; in_src_val = sv;
    @(negedge clk);
    checks++;
    if (out_valid !== ev || out_we !== ewe || out_unpred !== eunp ||
        out_unknown !== eunk || (ev && (out_dest !== edst || out_data !== edat))) begin
      errors++;
      $display("FAIL %s: got v=%b we=%b unp=%b unk=%b dst=%h dat=%h exp v=%b we=%b unp=%b unk=%b dst=%h dat=%h",
               req, out_valid, out_we, out_unpred, out_unknown, out_dest, out_data,
               ev, ewe, eunp, eunk, edst, edat);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    logic [31:0] a;
    logic [31:0] b;
    rst = 1'b1; in_valid = 1'b1; in_insn = enc(4'h2, 4'h3, 5'd0, 5'd7);
    in_dest_val = '1; in_src_val = '1;
    @(negedge clk);
    // R9 reset holds outputs low even with a valid word presented
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      checks++;
      if (out_valid || out_we || out_unpred || out_unknown) begin
        errors++;
        $display("FAIL R9: got v=%b we=%b unp=%b unk=%b exp all 0",
                 out_valid, out_we, out_unpred, out_unknown);
      end
    end
    rst = 1'b0;

    // R3 R4 R5 R7: full sweep of positions for clear and insert
    for (int lo = 0; lo < 32; lo++) begin
      for (int hi = 0; hi < 32; hi++) begin
        logic [31:0] m;
        logic [3:0]  d;
        next_rand(a); next_rand(b);
        d = 4'((lo + hi) % 15);
        if (hi < lo) begin
          run("R5 clear", enc(4'hF, d, 5'(lo), 5'(hi)), a, b, 1, 0, 1, 0, d, 32'h0);
          run("R5 insert", enc(4'h1, d, 5'(lo), 5'(hi)), a, b, 1, 0, 1, 0, d, 32'h0);
        end else begin
          m = fmask(lo, hi);
          run((lo == 0 && hi == 31) ? "R7 clear" : "R3 clear",
              enc(4'hF, d, 5'(lo), 5'(hi)), a, b, 1, 1, 0, 0, d, a & ~m);
          run((lo == 0 && hi == 31) ? "R7 insert" : "R4 insert",
              enc(4'((lo + 3 * hi) % 15), d, 5'(lo), 5'(hi)), a, b, 1, 1, 0, 0, d,
              (a & ~m) | ((b << lo) & m));
        end
      end
    end

    // R7 explicit full field values
    run("R7 clear full", enc(4'hF, 4'h4, 5'd0, 5'd31), 32'hDEAD_BEEF, 32'h0, 1, 1, 0, 0, 4'h4, 32'h0);
    run("R7 insert full", enc(4'h5, 4'h4, 5'd0, 5'd31), 32'hDEAD_BEEF, 32'hCAFE_F00D, 1, 1, 0, 0, 4'h4, 32'hCAFE_F00D);

    // R6 destination 15
    run("R6 clear", enc(4'hF, 4'hF, 5'd3, 5'd9), 32'hFFFF_FFFF, 32'h1, 1, 0, 1, 0, 4'hF, 32'h0);
    run("R6 insert", enc(4'h7, 4'hF, 5'd0, 5'd4), 32'hFFFF_FFFF, 32'h1, 1, 0, 1, 0, 4'hF, 32'h0);

    // R1 R2: flip each fixed opcode bit; destination still reported
    for (int bit_i = 20; bit_i < 32; bit_i++) begin
      run("R1 opcode", enc(4'h2, 4'h6, 5'd4, 5'd12) ^ (32'h1 << bit_i), 32'h5555_5555, 32'hAAAA_AAAA,
          1, 0, 0, 1, 4'h6, 32'h0);
    end
    run("R1 bit15", enc(4'h2, 4'h9, 5'd4, 5'd12) | 32'h0000_8000, 32'h1, 32'h2, 1, 0, 0, 1, 4'h9, 32'h0);
    run("R1 bit5", enc(4'h2, 4'hA, 5'd4, 5'd12) | 32'h0000_0020, 32'h1, 32'h2, 1, 0, 0, 1, 4'hA, 32'h0);
    run("R1 zero word", 32'h0, 32'h1, 32'h2, 1, 0, 0, 1, 4'h0, 32'h0);

    // R2 destination field for every index
    for (int d = 0; d < 15; d++) begin
      run("R2 dest", enc(4'hF, 4'(d), 5'd8, 5'd15), 32'hFFFF_FFFF, 32'h0, 1, 1, 0, 0, 4'(d), 32'hFFFF_00FF);
    end

    // R8 idle cycles drop valid and strobes
    run("R8 idle", enc(4'h1, 4'h2, 5'd0, 5'd3), 32'h0, 32'hF, 0, 0, 0, 0, 4'h0, 32'h0);
    run("R8 resume", enc(4'h1, 4'h2, 5'd0, 5'd3), 32'h0, 32'hF, 1, 1, 0, 0, 4'h2, 32'hF);
    run("R8 idle after", enc(4'h1, 4'h2, 5'd31, 5'd0), 32'h0, 32'hF, 0, 0, 0, 0, 4'h0, 32'h0);

    // R9 mid-stream reset
    in_valid = 1'b1; in_insn = enc(4'h1, 4'h2, 5'd0, 5'd3); rst = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid || out_we || out_unpred || out_unknown) begin
      errors++;
      $display("FAIL R9: got v=%b we=%b exp 0 0", out_valid, out_we);
    end
    rst = 1'b0;
    run("R10 after reset", enc(4'h1, 4'h2, 5'd9, 5'd3), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 1, 0, 4'h2, 32'h0);

    finish_run();
  end

endmodule